// File: doc/BRIEF.md
# Debug Trigger Semaphore Register Block

This block sits on a peripheral bus and gives application bus masters a way to raise debug event flags that an external debug tool later collects. It holds three 32-bit registers: an enable mask, a startup word and a semaphore word. Every bus transfer carries the crossbar master ID of its requester, and that ID decides what the access does.

The CPU, DMA and network-controller masters can only set semaphore bits: their writes are ORed into the current value. Only the debug-port master may program the enable and startup registers, and it empties the semaphore by reading it, so each read hands the tool the flags raised since the previous read. A registered trigger output goes high while any semaphore bit that is also enabled is set. It drives the debug event output pin.

The bus side answers every request in the same cycle. Only accesses with all four byte strobes set change state.

Top module: `dbg_trig_sema`

## Requirements
- R1: After reset the enable, startup and semaphore registers read as zero and `trig_out` is low.
- R2: `rdy` is high in exactly the cycles where `req` is high. `rdata` is zero whenever there is no read request.
- R3: A write with `be`=4'hF to offset 0x8 by master ID 0 (CPU), 1 (DMA) or 2 (network) sets the semaphore to its old value ORed with `wdata`. No bit is ever cleared this way.
- R4: A read with `be`=4'hF of offset 0x8 by master ID 8 (debug port) returns the current semaphore value in that cycle and leaves the semaphore at zero after the clock edge.
- R5: The enable register (offset 0x0) and the startup register (offset 0x4) take `wdata` only on a `be`=4'hF write by master ID 8. A write to them from IDs 0, 1 or 2 leaves them unchanged.
- R6: Reads of offsets 0x0 and 0x4 by IDs 0, 1, 2 or 8 return the register contents with no side effect. A read of offset 0x8 by IDs 0, 1 or 2 returns the semaphore without clearing it.
- R7: A write with `be` other than 4'hF changes no register. A read with `be` other than 4'hF returns data and does not clear the semaphore.
- R8: A write to offset 0x8 by master ID 8 has no effect.
- R9: `trig_out` is high in the cycle after a clock edge at which (semaphore AND enable) is non-zero, and low otherwise. It rises one cycle after the write that made the AND non-zero.
- R10: An access with an unknown master ID, or to an offset other than 0x0, 0x4 or 0x8, changes no register, and a read of that kind returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request valid this cycle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Byte offset of the register |
| be | input | 4 | Byte strobes; only 4'hF counts as a full access |
| id | input | 4 | Crossbar master ID of the requester |
| wdata | input | 32 | Write data |
| rdy | output | 1 | Single-cycle access acknowledge |
| rdata | output | 32 | Read data, valid in the request cycle |
| trig_out | output | 1 | Registered debug trigger toward the event output pin |

## Verification
The assertions assume that `req`, `wr`, `addr`, `be`, `id` and `wdata` are free of X at every clock edge after reset, and that a request lasts one cycle and describes one access. The stimulus drives all inputs two nanoseconds after each rising edge from tasks and loops, and holds them at known values in idle cycles. The random phase draws master IDs from the four known values and one unknown one, draws offsets from the three mapped ones and one hole, and mixes in narrow strobes, so that every permission case comes up under the same checks.

// File: rtl/dbg_trig_sema.sv
module dbg_trig_sema #(
  parameter int DW     = 32,
  parameter int AW     = 4,
  parameter int IDW    = 4,
  parameter int ID_CPU = 0,
  parameter int ID_DMA = 1,
  parameter int ID_NET = 2,
  parameter int ID_DBG = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW/8-1:0] be,
  input  logic [IDW-1:0] id,
  input  logic [DW-1:0] wdata,
  output logic          rdy,
  output logic [DW-1:0] rdata,
  output logic          trig_out
);
  localparam int BEW = DW / 8;
  localparam logic [AW-1:0] OFF_EN  = AW'(0);
  localparam logic [AW-1:0] OFF_ST  = AW'(4);
  localparam logic [AW-1:0] OFF_SEM = AW'(8);

  logic [DW-1:0] en_q, st_q, sem_q;

  wire full    = (be == {BEW{1'b1}});
  wire is_app  = (id == IDW'(ID_CPU)) || (id == IDW'(ID_DMA)) || (id == IDW'(ID_NET));
  wire is_dbg  = (id == IDW'(ID_DBG));
  wire known   = is_app || is_dbg;
  wire hit_en  = (addr == OFF_EN);
  wire hit_st  = (addr == OFF_ST);
  wire hit_sem = (addr == OFF_SEM);

  wire wr_full = req && wr && full;
  wire ld_en   = wr_full && is_dbg && hit_en;
  wire ld_st   = wr_full && is_dbg && hit_st;
  wire set_sem = wr_full && is_app && hit_sem;
  wire clr_sem = req && !wr && full && is_dbg && hit_sem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= '0;
      st_q     <= '0;
      sem_q    <= '0;
      trig_out <= 1'b0;
    end else begin
      if (ld_en) en_q <= wdata;
      if (ld_st) st_q <= wdata;
      if (clr_sem)      sem_q <= '0;
      else if (set_sem) sem_q <= sem_q | wdata;
      trig_out <= |(sem_q & en_q);
    end
  end

  assign rdy = req;

  always_comb begin
    rdata = '0;
    if (req && !wr && known) begin
      if (hit_en)       rdata = en_q;
      else if (hit_st)  rdata = st_q;
      else if (hit_sem) rdata = sem_q;
    end
  end

  a_r3_or_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (req && wr && (be == {BEW{1'b1}}) && addr == OFF_SEM && id inside {IDW'(ID_CPU), IDW'(ID_DMA), IDW'(ID_NET)})
    |=> (sem_q == ($past(sem_q) | $past(wdata))));

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !wr && (be == {BEW{1'b1}}) && addr == OFF_SEM && id == IDW'(ID_DBG))
    |=> (sem_q == '0));

  a_r5_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (req && wr && id != IDW'(ID_DBG)) |=> ($stable(en_q) && $stable(st_q)));

  a_r7_narrow_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req && wr && be != {BEW{1'b1}}) |=> ($stable(en_q) && $stable(st_q) && $stable(sem_q)));

  a_r8_dbg_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (req && wr && id == IDW'(ID_DBG) && addr == OFF_SEM) |=> $stable(sem_q));

  a_r9_trig_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (trig_out == $past(|(sem_q & en_q))));

  a_r2_idle_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    !(req && !wr) |-> (rdata == '0));
endmodule

// File: tb/tb_dbg_trig_sema.sv
module tb_dbg_trig_sema;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, wr = 1'b0;
  logic [3:0] addr = '0, be = '0, id = '0;
  logic [31:0] wdata = '0;
  logic rdy, trig_out;
  logic [31:0] rdata;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dbg_trig_sema dut (.clk, .rst_n, .req, .wr, .addr, .be, .id, .wdata, .rdy, .rdata, .trig_out);

  // behavioural reference
  logic [31:0] m_en = 0, m_st = 0, m_sem = 0;
  logic m_trig = 0;

  function automatic bit app_id(input logic [3:0] i);
    return i == 0 || i == 1 || i == 2;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_st = 0; m_sem = 0; m_trig = 0;
    end else begin
      m_trig = (m_sem & m_en) != 0;
      if (req && be == 4'hF) begin
        if (wr && id == 8 && addr == 0) m_en = wdata;
        if (wr && id == 8 && addr == 4) m_st = wdata;
        if (wr && app_id(id) && addr == 8) m_sem = m_sem | wdata;
        if (!wr && id == 8 && addr == 8) m_sem = 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    logic [31:0] er;
    er = 0;
    if (req && !wr && (app_id(id) || id == 8))
      er = (addr == 0) ? m_en : (addr == 4) ? m_st : (addr == 8) ? m_sem : 0;
    chk("R2 rdy", {31'b0, rdy}, {31'b0, req});
    chk((req && !wr) ? "R6 rdata" : "R2 rdata", rdata, er);
    chk("R9 trig", {31'b0, trig_out}, {31'b0, m_trig});
  end

  task automatic acc(input logic [3:0] i, input logic w, input logic [3:0] a,
                     input logic [3:0] b, input logic [31:0] d, output logic [31:0] r);
    @(posedge clk); #2;
    req = 1; wr = w; id = i; addr = a; be = b; wdata = d;
    @(negedge clk); r = rdata;
    @(posedge clk); #2;
    req = 0; wr = 0; be = 0; wdata = 0;
  endtask

  initial begin
    #1600000;
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    acc(8, 0, 0, 4'hF, 0, r); chk("R1 en reset", r, 0);
    acc(8, 0, 4, 4'hF, 0, r); chk("R1 startup reset", r, 0);
    acc(0, 0, 8, 4'hF, 0, r); chk("R1 sem reset", r, 0);
    chk("R1 trig reset", {31'b0, trig_out}, 0);

    acc(0, 1, 8, 4'hF, 32'h5, r);
    acc(0, 0, 8, 4'hF, 0, r); chk("R3 cpu set", r, 32'h5);
    acc(1, 1, 8, 4'hF, 32'h30, r);
    acc(2, 1, 8, 4'hF, 32'h104, r);
    acc(1, 0, 8, 4'hF, 0, r); chk("R3 or accumulate", r, 32'h135);
    acc(2, 0, 8, 4'hF, 0, r); chk("R6 app read no clear", r, 32'h135);

    acc(0, 1, 0, 4'hF, 32'hFF, r);
    acc(8, 0, 0, 4'hF, 0, r); chk("R5 cpu cannot write enable", r, 0);
    acc(8, 1, 0, 4'h3, 32'h1, r);
    acc(8, 0, 0, 4'hF, 0, r); chk("R7 narrow write ignored", r, 0);
    chk("R9 trig low with no enable", {31'b0, trig_out}, 0);

    acc(8, 1, 0, 4'hF, 32'hF, r);
    chk("R9 trig not yet", {31'b0, trig_out}, 0);
    @(posedge clk); #2;
    chk("R9 trig one cycle later", {31'b0, trig_out}, 1);
    acc(0, 0, 0, 4'hF, 0, r); chk("R6 cpu reads enable", r, 32'hF);

    acc(8, 0, 8, 4'h1, 0, r); chk("R7 narrow read returns data", r, 32'h135);
    acc(8, 0, 8, 4'hF, 0, r); chk("R7 narrow read kept value", r, 32'h135);
    acc(8, 0, 8, 4'hF, 0, r); chk("R4 second read sees cleared", r, 0);
    acc(0, 1, 8, 4'hF, 32'h2, r);
    acc(8, 1, 8, 4'hF, 32'hFFFF, r);
    acc(0, 0, 8, 4'hF, 0, r); chk("R8 debug write no effect", r, 32'h2);
    acc(8, 0, 8, 4'hF, 0, r); chk("R4 read returns value", r, 32'h2);
    acc(0, 0, 8, 4'hF, 0, r); chk("R4 cleared after read", r, 0);
    @(posedge clk); #2;
    chk("R9 trig drops", {31'b0, trig_out}, 0);

    acc(8, 1, 4, 4'hF, 32'hABCD, r);
    acc(1, 1, 4, 4'hF, 32'h1111, r);
    acc(1, 0, 4, 4'hF, 0, r); chk("R5 startup written by debug only", r, 32'hABCD);

    acc(5, 1, 8, 4'hF, 32'h8, r);
    acc(5, 0, 4, 4'hF, 0, r); chk("R10 unknown id reads zero", r, 0);
    acc(0, 0, 8, 4'hF, 0, r); chk("R10 unknown id write ignored", r, 0);
    acc(8, 1, 4'hC, 4'hF, 32'h7, r);
    acc(8, 0, 4'hC, 4'hF, 0, r); chk("R10 hole reads zero", r, 0);

    for (int k = 0; k < 600; k++) begin
      @(posedge clk); #2;
      req = $urandom_range(0, 3) != 0;
      wr = $urandom_range(0, 1) == 1;
      case ($urandom_range(0, 4))
        0: id = 0; 1: id = 1; 2: id = 2; 3: id = 8; default: id = 5;
      endcase
      addr = 4'($urandom_range(0, 3) * 4);
      be = ($urandom_range(0, 5) == 0) ? 4'($urandom_range(0, 14)) : 4'hF;
      wdata = $urandom & $urandom;
    end
    @(posedge clk); #2;
    req = 0; wr = 0; be = 0;
    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule